// File: doc/BRIEF.md
# Clocked Serial I/O Transceiver

This block moves one byte at a time over a three-wire synchronous link: a clock pin, a data-out pin and a data-in pin. Software writes a byte into the transfer register. The engine then drives the byte out bit by bit and assembles the byte it receives from the data-in pin at the same time. When the eighth bit has been taken in, the block raises an interrupt request, sets its transfer-complete flag and presents the received byte on the read port.

The transfer clock comes from one of two sources. In internal mode, a programmable divider in the block generates it and the block drives it onto the clock pin. In external mode, a remote master supplies it; the block synchronises it and detects its edges. One select chooses the clock polarity, and with it the resting level of the clock pin. A second select chooses whether the least or the most significant bit goes first. In internal mode the free-running divider sets when a new byte may start, so a write can wait up to one and a half transfer-clock periods before the first edge appears. Once the byte is finished, the data-out driver is released to high impedance.

Top module: `csio_xcvr`

## Requirements
- R1: Every transfer moves exactly 8 bits. The interrupt request rises on the capture edge of the eighth bit, and rd_data holds the full received byte from that same cycle until the next completion.
- R2: With cfg_pol = 0, sdo takes a new bit on the falling edge of the transfer clock and sdi is sampled on the rising edge. In internal mode sck_o rests high while no transfer is running.
- R3: With cfg_pol = 1 the edges swap: data launches on the rising edge and is sampled on the falling edge. In internal mode sck_o rests low between transfers.
- R4: With cfg_msb_first = 0, bit 0 is sent and received first. With cfg_msb_first = 1, bit 7 goes first. rd_data always holds each received bit in its natural position.
- R5: In internal mode, the first edge on sck_o comes no more than 3*(cfg_div+1) system clock cycles after the write cycle, which is 1.5 transfer-clock periods.
- R6: In internal mode, sdo_oe is 1 from the accepted write until the transfer completes, and 0 at all other times.
- R7: irq is set when a transfer completes and stays at 1 until irq_clr is asserted.
- R8: xfer_done is 1 out of reset and 1 after each completion. It is 0 from the accepted write until the completion.
- R9: In external mode, sck_oe is 0, transfer-clock edges are taken from sck_i through a synchroniser, and sdo_oe stays at 1.
- R10: A write made while a transfer is pending or in progress is ignored. Both the bits sent and the byte received are those of the transfer already running.
- R11: In internal mode, every half period of the transfer clock lasts exactly cfg_div+1 system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the transfer register |
| wr_data | input | DATA_W | Byte to transmit |
| rd_data | output | DATA_W | Last received byte |
| cfg_int_clk | input | 1 | 1: internal transfer clock, 0: external |
| cfg_pol | input | 1 | Clock polarity select |
| cfg_msb_first | input | 1 | 1: MSB first, 0: LSB first |
| cfg_div | input | DIV_W | Divider; half period = cfg_div+1 cycles |
| irq_clr | input | 1 | Clears the interrupt request |
| irq | output | 1 | Interrupt request, held until cleared |
| xfer_done | output | 1 | Transfer-complete status flag |
| sck_i | input | 1 | Transfer clock from pin (external mode) |
| sck_o | output | 1 | Transfer clock to pin (internal mode) |
| sck_oe | output | 1 | Clock pin output enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Data-out pin output enable |

## Verification
The hardest case to reach from the ports is a second write that lands in the middle of a running byte, while the divider phase and the engine's half-bit state are both mid-way. The stimulus reaches it by starting an internal-mode transfer and then writing an all-ones byte a fixed number of cycles later. A slave model answers on the pins at the same time, so the corrupted case would show up both in the captured data-out stream and in the received byte. The external-clock cases need a master model that drives slow clock edges, so that both the synchroniser latency and the hold time on sdi are exercised in each polarity.

// File: rtl/csio_pkg.sv
package csio_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_SHIFT = 2'd2
   } csio_state_e;
endpackage

// File: rtl/csio_clkdiv.sv
// Free-running divider: ticks alternate between launch and capture phases.
module csio_clkdiv #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             launch,
   output logic             capture
);
   logic [DIV_W-1:0] cnt;
   logic             ph;
   logic             tick;

   assign tick    = (cnt >= div);
   assign launch  = tick & ~ph;
   assign capture = tick & ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         ph  <= 1'b0;
      end else if (tick) begin
         cnt <= '0;
         ph  <= ~ph;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/csio_sync.sv
// Multi-stage synchroniser with edge detection for an external clock.
module csio_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= RST_VAL;
               else        chain[g] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= RST_VAL;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= RST_VAL;
      else        prev <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~prev;
   assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/csio_shift.sv
// Shift engine: arm on write, launch on launch events, sample on capture events.
module csio_shift
   import csio_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              msb_first,
   input  logic              launch,
   input  logic              capture,
   input  logic              sdi,
   output logic              busy,
   output logic              lhalf,
   output logic              sdo,
   output logic              done,
   output logic [DATA_W-1:0] rx_next
);
   localparam int              IW   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [IW-1:0]   LAST = IW'(DATA_W - 1);

   csio_state_e       st;
   logic [IW-1:0]     idx;
   logic [IW-1:0]     pos;
   logic [DATA_W-1:0] tx_q;
   logic [DATA_W-1:0] rx_q;
   logic              msb_q;
   logic              lh_q;
   logic              sdo_q;

   assign pos   = msb_q ? (LAST - idx) : idx;
   assign busy  = (st != ST_IDLE);
   assign lhalf = lh_q;
   assign sdo   = sdo_q;
   assign done  = (st == ST_SHIFT) && capture && lh_q && (idx == LAST);

   always_comb begin
      rx_next      = rx_q;
      rx_next[pos] = sdi;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         idx   <= '0;
         tx_q  <= '0;
         rx_q  <= '0;
         msb_q <= 1'b0;
         lh_q  <= 1'b0;
         sdo_q <= 1'b1;
      end else begin
         case (st)
            ST_IDLE: if (start) begin
               tx_q  <= tx_byte;
               msb_q <= msb_first;
               idx   <= '0;
               st    <= ST_ARMED;
            end
            ST_ARMED: if (launch) begin
               sdo_q <= tx_q[pos];
               lh_q  <= 1'b1;
               st    <= ST_SHIFT;
            end
            ST_SHIFT: begin
               if (capture && lh_q) begin
                  rx_q[pos] <= sdi;
                  lh_q      <= 1'b0;
                  if (idx == LAST) st  <= ST_IDLE;
                  else             idx <= idx + 1'b1;
               end else if (launch && !lh_q) begin
                  sdo_q <= tx_q[pos];
                  lh_q  <= 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/csio_xcvr.sv
module csio_xcvr
   import csio_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              cfg_int_clk,
   input  logic              cfg_pol,
   input  logic              cfg_msb_first,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic              irq_clr,
   output logic              irq,
   output logic              xfer_done,
   input  logic              sck_i,
   output logic              sck_o,
   output logic              sck_oe,
   input  logic              sdi,
   output logic              sdo,
   output logic              sdo_oe
);
   generate
      if (DATA_W < 2)      begin : g_bad_w  $error("DATA_W must be at least 2"); end
      if (DIV_W < 1)       begin : g_bad_d  $error("DIV_W must be at least 1"); end
      if (SYNC_STAGES < 2) begin : g_bad_s  $error("SYNC_STAGES must be at least 2"); end
   endgenerate

   logic              int_launch, int_capture;
   logic              ext_rise, ext_fall;
   logic              launch, capture;
   logic              busy, lhalf, eng_done, accept;
   logic [DATA_W-1:0] rx_next;
   logic              irq_q, done_q;
   logic [DATA_W-1:0] rd_q;

   csio_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .div(cfg_div),
      .launch(int_launch), .capture(int_capture)
   );

   csio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(sck_i),
      .rise(ext_rise), .fall(ext_fall)
   );

   always_comb begin
      if (cfg_int_clk) begin
         launch  = int_launch;
         capture = int_capture;
      end else begin
         launch  = cfg_pol ? ext_rise : ext_fall;
         capture = cfg_pol ? ext_fall : ext_rise;
      end
   end

   assign accept = wr_en && !busy;

   csio_shift #(.DATA_W(DATA_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(accept), .tx_byte(wr_data),
      .msb_first(cfg_msb_first), .launch(launch), .capture(capture),
      .sdi(sdi), .busy(busy), .lhalf(lhalf), .sdo(sdo),
      .done(eng_done), .rx_next(rx_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q  <= 1'b0;
         done_q <= 1'b1;
         rd_q   <= '0;
      end else if (eng_done) begin
         irq_q  <= 1'b1;
         done_q <= 1'b1;
         rd_q   <= rx_next;
      end else begin
         if (irq_clr) irq_q  <= 1'b0;
         if (accept)  done_q <= 1'b0;
      end
   end

   assign irq       = irq_q;
   assign xfer_done = done_q;
   assign rd_data   = rd_q;
   assign sck_oe    = cfg_int_clk;
   assign sck_o     = (cfg_int_clk && lhalf) ? cfg_pol : ~cfg_pol;
   assign sdo_oe    = cfg_int_clk ? busy : 1'b1;
endmodule

// File: rtl/csio_xcvr_chk.sv
module csio_xcvr_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_int_clk,
   input logic              cfg_pol,
   input logic              irq_clr,
   input logic              irq,
   input logic              xfer_done,
   input logic [DATA_W-1:0] rd_data,
   input logic              sck_o,
   input logic              sck_oe,
   input logic              sdo_oe
);
   p_oe_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_int_clk && xfer_done) |-> !sdo_oe);

   p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);

   p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $rose(xfer_done));

   p_idle_lvl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_int_clk && xfer_done) |-> (sck_o == !cfg_pol));

   p_ext_pins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_int_clk |-> (sdo_oe && !sck_oe));

   p_rd_update_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_data) |-> $rose(xfer_done));
endmodule

bind csio_xcvr csio_xcvr_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_int_clk(cfg_int_clk), .cfg_pol(cfg_pol),
   .irq_clr(irq_clr), .irq(irq), .xfer_done(xfer_done), .rd_data(rd_data),
   .sck_o(sck_o), .sck_oe(sck_oe), .sdo_oe(sdo_oe)
);

// File: tb/csio_xcvr_bench.sv
module csio_xcvr_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       cfg_int_clk = 1'b1;
   logic       cfg_pol = 1'b0;
   logic       cfg_msb_first = 1'b0;
   logic [7:0] cfg_div = 8'd2;
   logic       irq_clr = 1'b0;
   logic       irq, xfer_done, sck_o, sck_oe, sdo, sdo_oe;
   logic       sck_i = 1'b1;
   logic       sdi = 1'b0;

   csio_xcvr u_csio_xcvr (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .cfg_int_clk(cfg_int_clk), .cfg_pol(cfg_pol),
      .cfg_msb_first(cfg_msb_first), .cfg_div(cfg_div), .irq_clr(irq_clr),
      .irq(irq), .xfer_done(xfer_done), .sck_i(sck_i), .sck_o(sck_o),
      .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   always @(posedge clk) cyc++;

   typedef struct {
      logic [7:0] tx;
      logic [7:0] rx;
      bit         internal;
   } item_t;
   item_t sb[$];

   logic [7:0] cur_rx = '0;
   bit         cur_msb = 1'b0;
   logic [7:0] cap = '0;
   int         cap_n = 0;
   int         wr_time = 0;
   int         first_edge = -1;
   int         last_edge = -1;
   int         half_err = 0;
   logic       sck_prev = 1'b1;
   logic       irq_q = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Driver: push the expected item, then strobe the write.
   task automatic start_xfer(input logic [7:0] tx, input logic [7:0] rx);
      item_t it;
      it.tx = tx; it.rx = rx; it.internal = cfg_int_clk;
      sb.push_back(it);
      cur_rx = rx; cur_msb = cfg_msb_first; cap = '0; cap_n = 0;
      first_edge = -1; last_edge = -1; half_err = 0;
      @(negedge clk);
      wr_data = tx; wr_en = 1'b1; wr_time = cyc;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_done();
      while (!xfer_done) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic clear_irq();
      @(negedge clk); irq_clr = 1'b1;
      @(negedge clk); irq_clr = 1'b0;
   endtask

   // External master: launch edge, then capture edge, eight times.
   task automatic ext_byte();
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         sck_i = cfg_pol;
         sdi = cur_msb ? cur_rx[7-k] : cur_rx[k];
         repeat (8) @(negedge clk);
         cap[cur_msb ? 7-k : k] = sdo;
         cap_n++;
         sck_i = ~cfg_pol;
         repeat (7) @(negedge clk);
      end
      repeat (6) @(negedge clk);
   endtask

   // Internal-mode slave model watching sck_o.
   always @(negedge clk) begin
      if (rst_n && cfg_int_clk && (sck_o !== sck_prev)) begin
         if (first_edge < 0) first_edge = cyc;
         if (last_edge >= 0 && (cyc - last_edge) != (int'(cfg_div) + 1)) half_err++;
         last_edge = cyc;
         if (sck_o == cfg_pol) begin
            if (cap_n < 8) sdi = cur_msb ? cur_rx[7-cap_n] : cur_rx[cap_n];
         end else begin
            if (cap_n < 8) cap[cur_msb ? 7-cap_n : cap_n] = sdo;
            cap_n++;
         end
      end
      sck_prev = sck_o;
   end

   // Monitor: on each rising irq, pop and compare.
   always begin
      @(negedge clk);
      if (rst_n && irq && !irq_q) begin
         @(negedge clk);
         if (sb.size() == 0) begin
            chk(1'b0, "R7 irq with empty scoreboard", 1, 0);
         end else begin
            item_t e;
            e = sb.pop_front();
            chk(cap_n == 8, "R1 bit count", cap_n, 8);
            chk(rd_data == e.rx, "R4 received byte", rd_data, e.rx);
            chk(cap == e.tx, "R2/R3 transmitted bits", cap, e.tx);
            chk(xfer_done == 1'b1, "R8 done flag after completion", xfer_done, 1);
            if (e.internal) begin
               chk((first_edge - wr_time) <= 3 * (int'(cfg_div) + 1), "R5 start latency",
                   first_edge - wr_time, 3 * (int'(cfg_div) + 1));
               chk(half_err == 0, "R11 half period length", half_err, 0);
               chk(sdo_oe == 1'b0, "R6 sdo released after byte", sdo_oe, 0);
            end
         end
      end
      irq_q = irq;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk(irq == 1'b0, "R7 reset irq", irq, 0);
      chk(xfer_done == 1'b1, "R8 reset done flag", xfer_done, 1);
      chk(sdo_oe == 1'b0, "R6 reset sdo_oe", sdo_oe, 0);
      chk(sck_o == 1'b1, "R2 idle high pol0", sck_o, 1);
      chk(rd_data == 8'h00, "R1 reset rd_data", rd_data, 0);

      // internal, pol0, LSB first
      start_xfer(8'hA5, 8'h3C);
      repeat (3) @(negedge clk);
      chk(xfer_done == 1'b0, "R8 flag low while busy", xfer_done, 0);
      chk(sdo_oe == 1'b1, "R6 sdo driven while busy", sdo_oe, 1);
      wait_done();
      repeat (20) @(negedge clk);
      chk(irq == 1'b1, "R7 irq held", irq, 1);
      clear_irq();
      @(negedge clk);
      chk(irq == 1'b0, "R7 irq cleared", irq, 0);

      // internal, pol1, MSB first
      cfg_pol = 1'b1; cfg_msb_first = 1'b1; cfg_div = 8'd4;
      @(negedge clk);
      chk(sck_o == 1'b0, "R3 idle low pol1", sck_o, 0);
      start_xfer(8'h81, 8'hE7);
      wait_done();
      chk(sck_o == 1'b0, "R3 idle low after byte", sck_o, 0);
      clear_irq();

      // R10: write during an active transfer
      cfg_pol = 1'b0; cfg_msb_first = 1'b0; cfg_div = 8'd3;
      @(negedge clk);
      start_xfer(8'h5A, 8'hC3);
      repeat (20) @(negedge clk);
      wr_data = 8'hFF; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      wait_done();
      chk(rd_data == 8'hC3, "R10 overlapping write ignored", rd_data, 8'hC3);
      chk(cap == 8'h5A, "R10 tx bits unaffected", cap, 8'h5A);
      clear_irq();

      // external, pol0, LSB first
      cfg_int_clk = 1'b0; sck_i = 1'b1;
      repeat (6) @(negedge clk);
      chk(sck_oe == 1'b0, "R9 clock pin input", sck_oe, 0);
      chk(sdo_oe == 1'b1, "R9 sdo driven idle", sdo_oe, 1);
      start_xfer(8'h96, 8'h69);
      ext_byte();
      wait_done();
      clear_irq();

      // external, pol1, MSB first
      cfg_pol = 1'b1; cfg_msb_first = 1'b1; sck_i = 1'b0;
      repeat (6) @(negedge clk);
      start_xfer(8'h2B, 8'hD4);
      ext_byte();
      wait_done();
      chk(sdo_oe == 1'b1, "R9 sdo driven after byte", sdo_oe, 1);
      clear_irq();

      repeat (5) @(negedge clk);
      chk(sb.size() == 0, "R1 all transfers completed", sb.size(), 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule